// File: doc/BRIEF.md
# High-Speed Data Lane Burst Sequencer

This block drives the transmit side of a single high-speed serial data lane. It waits in the low-power stop state (LP-11) until a burst is requested and the companion clock lane reports that it is ready. It then steps the lane through request (LP-01), bridge (LP-00) and high-speed zero (HS-0). Next it shifts out a fixed sync byte followed by the payload bytes, one bit per clock cycle, where one clock cycle equals one unit interval (UI).

After the final payload bit the lane holds the complement of that bit for a trail interval. It then returns to LP-11 and holds there for an exit interval before the next burst may begin. Payload arrives on a byte stream with valid, last and ready signals. The stream is consumed only on byte boundaries inside the high-speed data phase.

Every phase length comes from a configuration input counted in UI. The block raises any length below its timing floor to that floor, and lowers the prepare length to its ceiling. The floors and the ceiling are derived from the UI length in picoseconds (parameter `UI_PS`). The outputs are a lane-state code and the serial high-speed bit. The analog drivers sit outside this block.

Top module: `dlane_hs_seq`

## Requirements
- R1: During and right after reset the lane code is LP-11, `hs_bit` is 0 and `s_ready` is 0. Lane codes: 0 = LP-11, 1 = LP-01, 2 = LP-00, 3 = HS-0, 4 = HS data (sync and payload), 5 = HS trail.
- R2: A burst leaves LP-11 only when `burst_req` and `clk_lane_ready` are both high at a rising edge. The entry order is code 1, then 2, then 3, then 4.
- R3: Code 1 lasts max(`cfg_lpx`, ceil(50000/UI_PS)) cycles.
- R4: Code 2 lasts `cfg_prep` clamped to the range [ceil(40000/UI_PS)+4, floor(85000/UI_PS)+6] cycles.
- R5: Code 3 lasts max(`cfg_zero`, 1) cycles, and `hs_bit` is 0 throughout it.
- R6: The data phase first sends the sync byte 8'hB8, then the accepted payload bytes back to back. Every byte is sent least significant bit first, one bit per cycle.
- R7: `s_ready` is high only in the cycle that carries bit 7 of a byte in the data phase, and never after a byte flagged last has been accepted. A byte is accepted when `s_ready` and `s_valid` are both high at a rising edge.
- R8: Serialisation ends after the byte accepted with `s_last` high, or after any byte at whose final bit no valid byte is offered.
- R9: The trail (code 5) drives the complement of the final bit sent, for max(`cfg_trail`, max(8, ceil(60000/UI_PS)+4)) cycles.
- R10: After the trail the lane shows LP-11 for max(`cfg_exit`, ceil(100000/UI_PS)) cycles. If `burst_req` and `clk_lane_ready` are high at the end of that hold, code 1 follows immediately; otherwise the lane stays in LP-11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one cycle per UI |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_req | input | 1 | Request to start a burst |
| clk_lane_ready | input | 1 | Clock lane is running in high-speed mode |
| cfg_lpx | input | CW | Request (LP-01) length in UI |
| cfg_prep | input | CW | Bridge (LP-00) length in UI |
| cfg_zero | input | CW | HS-0 length in UI |
| cfg_trail | input | CW | Trail length in UI |
| cfg_exit | input | CW | Post-burst LP-11 hold in UI |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte is valid |
| s_last | input | 1 | Payload byte is the last of the burst |
| s_ready | output | 1 | Payload byte is accepted this cycle |
| lane_code | output | 3 | Lane state code |
| hs_bit | output | 1 | Serial high-speed bit |

## Verification
The bench builds the block with `UI_PS` = 10000 and `CW` = 8. This gives floors of 5 (request), 8 (prepare), 10 (trail) and 10 (exit) UI and a prepare ceiling of 14 UI. With limits this small, configuration values below every floor and above the prepare ceiling can be tried in short bursts. The same settings keep bursts with no payload, bursts that end when valid drops, and back-to-back bursts under a held request to a few dozen cycles each. Every case is compared cycle by cycle against a trace of lane codes and bits that the bench derives from the requirements.

// File: rtl/dlane_pkg.sv
`timescale 1ns/1ps
package dlane_pkg;

   typedef enum logic [2:0] {
      LC_STOP   = 3'd0,
      LC_HSRQ   = 3'd1,
      LC_BRIDGE = 3'd2,
      LC_HSZERO = 3'd3,
      LC_HSDATA = 3'd4,
      LC_TRAIL  = 3'd5
   } lane_code_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RQST,
      S_PREP,
      S_ZERO,
      S_SHIFT,
      S_TRAIL,
      S_HOLD
   } seq_state_e;

   localparam logic [7:0] SYNC_WORD = 8'hB8;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/dlane_phase_timer.sv
`timescale 1ns/1ps
module dlane_phase_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_len,
   output logic         done
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_len - ONE;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - ONE;
   end

   assign done = (cnt_q == '0);

   // R3: every timed phase is loaded with a length of at least one cycle
   p_load_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_len != '0));

endmodule

// File: rtl/dlane_serializer.sv
`timescale 1ns/1ps
module dlane_serializer #(
   parameter logic [7:0] SYNC = 8'hB8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld_sync,
   input  logic       ld_byte,
   input  logic       shift,
   input  logic [7:0] byte_in,
   output logic       bit_o,
   output logic       at_end,
   output logic       tail_bit
);

   logic [7:0] sreg_q;
   logic [2:0] idx_q;
   logic       tail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         idx_q  <= '0;
         tail_q <= 1'b0;
      end else if (ld_sync) begin
         sreg_q <= SYNC;
         idx_q  <= '0;
      end else if (ld_byte) begin
         sreg_q <= byte_in;
         idx_q  <= '0;
         tail_q <= sreg_q[0];
      end else if (shift) begin
         sreg_q <= {1'b0, sreg_q[7:1]};
         idx_q  <= idx_q + 3'd1;
         tail_q <= sreg_q[0];
      end
   end

   assign bit_o    = sreg_q[0];
   assign at_end   = (idx_q == 3'd7);
   assign tail_bit = tail_q;

   // R6: a new byte is taken only on the final bit of the current one
   p_load_on_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_byte |-> at_end);

endmodule

// File: rtl/dlane_hs_seq.sv
`timescale 1ns/1ps
module dlane_hs_seq
   import dlane_pkg::*;
#(
   parameter int UI_PS = 2000,
   parameter int CW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          burst_req,
   input  logic          clk_lane_ready,
   input  logic [CW-1:0] cfg_lpx,
   input  logic [CW-1:0] cfg_prep,
   input  logic [CW-1:0] cfg_zero,
   input  logic [CW-1:0] cfg_trail,
   input  logic [CW-1:0] cfg_exit,
   input  logic [7:0]    s_data,
   input  logic          s_valid,
   input  logic          s_last,
   output logic          s_ready,
   output logic [2:0]    lane_code,
   output logic          hs_bit
);

   localparam int LPX_MIN   = ceil_div(50000, UI_PS);
   localparam int PREP_MIN  = ceil_div(40000, UI_PS) + 4;
   localparam int PREP_MAX  = (85000 / UI_PS) + 6;
   localparam int TRAIL_RAW = ceil_div(60000, UI_PS) + 4;
   localparam int TRAIL_MIN = (TRAIL_RAW > 8) ? TRAIL_RAW : 8;
   localparam int EXIT_MIN  = ceil_div(100000, UI_PS);
   localparam int CFG_TOP   = (1 << CW) - 1;

   generate
      if (UI_PS < 1) begin : g_bad_ui
         $error("UI_PS must be positive");
      end
      if (CW < 2 || CW > 16) begin : g_bad_cw
         $error("CW out of range");
      end
      if (PREP_MIN > PREP_MAX) begin : g_bad_prep
         $error("prepare window is empty");
      end
      if (LPX_MIN > CFG_TOP || PREP_MAX > CFG_TOP ||
          TRAIL_MIN > CFG_TOP || EXIT_MIN > CFG_TOP) begin : g_bad_fit
         $error("timing floors do not fit CW bits");
      end
   endgenerate

   localparam logic [CW-1:0] LPX_V   = LPX_MIN[CW-1:0];
   localparam logic [CW-1:0] PMIN_V  = PREP_MIN[CW-1:0];
   localparam logic [CW-1:0] PMAX_V  = PREP_MAX[CW-1:0];
   localparam logic [CW-1:0] TRAIL_V = TRAIL_MIN[CW-1:0];
   localparam logic [CW-1:0] EXIT_V  = EXIT_MIN[CW-1:0];
   localparam logic [CW-1:0] ONE_V   = {{(CW-1){1'b0}}, 1'b1};

   // effective phase lengths after floor / ceiling
   logic [CW-1:0] lpx_eff, prep_eff, zero_eff, trail_eff, exit_eff;

   always_comb begin
      lpx_eff   = (cfg_lpx   < LPX_V)   ? LPX_V   : cfg_lpx;
      trail_eff = (cfg_trail < TRAIL_V) ? TRAIL_V : cfg_trail;
      exit_eff  = (cfg_exit  < EXIT_V)  ? EXIT_V  : cfg_exit;
      zero_eff  = (cfg_zero == '0)      ? ONE_V   : cfg_zero;
      if (cfg_prep < PMIN_V)
         prep_eff = PMIN_V;
      else if (cfg_prep > PMAX_V)
         prep_eff = PMAX_V;
      else
         prep_eff = cfg_prep;
   end

   seq_state_e    state_q, state_d;
   logic          tmr_load, tmr_done;
   logic [CW-1:0] tmr_len;
   logic          ld_sync, ld_byte, shift;
   logic          ser_bit, ser_end, ser_tail;
   logic          last_seen_q;
   logic          take, go;
   lane_code_e    code_c;

   dlane_phase_timer #(.W(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_len (tmr_len),
      .done     (tmr_done)
   );

   dlane_serializer #(.SYNC(SYNC_WORD)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_sync  (ld_sync),
      .ld_byte  (ld_byte),
      .shift    (shift),
      .byte_in  (s_data),
      .bit_o    (ser_bit),
      .at_end   (ser_end),
      .tail_bit (ser_tail)
   );

   assign go      = burst_req && clk_lane_ready;
   assign s_ready = (state_q == S_SHIFT) && ser_end && !last_seen_q;
   assign take    = s_ready && s_valid;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_len  = ONE_V;
      ld_sync  = 1'b0;
      ld_byte  = 1'b0;
      shift    = 1'b0;
      unique case (state_q)
         S_IDLE: if (go) begin
            state_d = S_RQST; tmr_load = 1'b1; tmr_len = lpx_eff;
         end
         S_RQST: if (tmr_done) begin
            state_d = S_PREP; tmr_load = 1'b1; tmr_len = prep_eff;
         end
         S_PREP: if (tmr_done) begin
            state_d = S_ZERO; tmr_load = 1'b1; tmr_len = zero_eff;
         end
         S_ZERO: if (tmr_done) begin
            state_d = S_SHIFT; ld_sync = 1'b1;
         end
         S_SHIFT: begin
            if (ser_end && take) begin
               ld_byte = 1'b1;
            end else begin
               shift = 1'b1;
               if (ser_end) begin
                  state_d = S_TRAIL; tmr_load = 1'b1; tmr_len = trail_eff;
               end
            end
         end
         S_TRAIL: if (tmr_done) begin
            state_d = S_HOLD; tmr_load = 1'b1; tmr_len = exit_eff;
         end
         S_HOLD: if (tmr_done) begin
            if (go) begin
               state_d = S_RQST; tmr_load = 1'b1; tmr_len = lpx_eff;
            end else begin
               state_d = S_IDLE;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         last_seen_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (ld_sync)
            last_seen_q <= 1'b0;
         else if (take && s_last)
            last_seen_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (state_q)
         S_RQST:  code_c = LC_HSRQ;
         S_PREP:  code_c = LC_BRIDGE;
         S_ZERO:  code_c = LC_HSZERO;
         S_SHIFT: code_c = LC_HSDATA;
         S_TRAIL: code_c = LC_TRAIL;
         default: code_c = LC_STOP;
      endcase
   end

   assign lane_code = code_c;
   assign hs_bit    = (state_q == S_SHIFT) ? ser_bit :
                      (state_q == S_TRAIL) ? ~ser_tail : 1'b0;

   // R7: stream is only accepted inside the data phase
   p_ready_in_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (lane_code == LC_HSDATA));

   // R2: leaving LP-11 always goes to LP-01
   p_entry_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lane_code) == LC_STOP && lane_code != LC_STOP) |-> (lane_code == LC_HSRQ));

   // R4: the bridge state is followed by HS-0
   p_bridge_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lane_code) == LC_BRIDGE && lane_code != LC_BRIDGE) |-> (lane_code == LC_HSZERO));

   // R9: first trail bit is the complement of the last data bit
   p_trail_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lane_code) == LC_HSDATA && lane_code == LC_TRAIL) |-> (hs_bit != $past(hs_bit)));

   // R10: the trail returns the lane to LP-11
   p_trail_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lane_code) == LC_TRAIL && lane_code != LC_TRAIL) |-> (lane_code == LC_STOP));

endmodule

// File: tb/tb_dlane_hs_seq.sv
`timescale 1ns/1ps
module tb_dlane_hs_seq;

   localparam int UI     = 10000;
   localparam int CW     = 8;
   localparam int F_LPX  = (50000 + UI - 1) / UI;
   localparam int F_PMIN = (40000 + UI - 1) / UI + 4;
   localparam int F_PMAX = 85000 / UI + 6;
   localparam int F_TRL0 = (60000 + UI - 1) / UI + 4;
   localparam int F_TRL  = (F_TRL0 > 8) ? F_TRL0 : 8;
   localparam int F_EXIT = (100000 + UI - 1) / UI;
   localparam logic [7:0] SYNC_B = 8'hB8;

   typedef struct {
      logic [2:0] code;
      logic       b;
      int         rq;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          burst_req = 1'b0;
   logic          clk_lane_ready = 1'b1;
   logic [CW-1:0] cfg_lpx = '0, cfg_prep = '0, cfg_zero = '0, cfg_trail = '0, cfg_exit = '0;
   logic [7:0]    s_data = '0;
   logic          s_valid = 1'b0;
   logic          s_last = 1'b0;
   logic          s_ready;
   logic [2:0]    lane_code;
   logic          hs_bit;

   int   checks = 0;
   int   errors = 0;
   int   taken = 0;
   bit   ended = 1'b0;
   exp_t expq[$];
   logic [8:0] fq[$];

   always #10 clk = ~clk;

   dlane_hs_seq #(.UI_PS(UI), .CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .clk_lane_ready(clk_lane_ready),
      .cfg_lpx(cfg_lpx), .cfg_prep(cfg_prep), .cfg_zero(cfg_zero),
      .cfg_trail(cfg_trail), .cfg_exit(cfg_exit),
      .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
      .lane_code(lane_code), .hs_bit(hs_bit)
   );

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic push_exp(input logic [2:0] c, input logic b, input int rq, input int n);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.code = c; e.b = b; e.rq = rq;
         expq.push_back(e);
      end
   endtask

   // expected trace of one burst, derived from R2..R10
   task automatic push_trace(input int lpx, input int prep, input int zero, input int trl,
                             input int ext, input logic [7:0] bytes[$],
                             input bit fresh, input bit tail_stop);
      logic lastb;
      int   pe;
      pe = (prep < F_PMIN) ? F_PMIN : ((prep > F_PMAX) ? F_PMAX : prep);
      if (fresh) push_exp(3'd0, 1'b0, 2, 1);                 // R2 still LP-11
      push_exp(3'd1, 1'b0, 3, imax(lpx, F_LPX));             // R3
      push_exp(3'd2, 1'b0, 4, pe);                           // R4
      push_exp(3'd3, 1'b0, 5, imax(zero, 1));                // R5
      for (int i = 0; i < 8; i++) push_exp(3'd4, SYNC_B[i], 6, 1);  // R6 sync
      lastb = SYNC_B[7];
      foreach (bytes[k]) begin
         for (int i = 0; i < 8; i++) push_exp(3'd4, bytes[k][i], 6, 1); // R6 payload
         lastb = bytes[k][7];
      end
      push_exp(3'd5, ~lastb, 9, imax(trl, F_TRL));           // R9
      push_exp(3'd0, 1'b0, 10, imax(ext, F_EXIT));           // R10
      if (tail_stop) push_exp(3'd0, 1'b0, 10, 1);
   endtask

   // monitor: compares each cycle away from the rising edge
   always @(negedge clk) begin
      if (rst_n && expq.size() > 0) begin
         exp_t e;
         e = expq.pop_front();
         chk(lane_code == e.code, $sformatf("R%0d", e.rq), "lane_code", lane_code, e.code);
         chk(hs_bit == e.b, $sformatf("R%0d", e.rq), "hs_bit", hs_bit, e.b);
         // R7: ready only inside the data phase
         chk(!(s_ready && lane_code != 3'd4), "R7", "ready outside data", s_ready, 0);
      end
   end

   // feeder: presents the byte queue on the stream
   always @(posedge clk) begin
      logic hs;
      hs = s_ready && s_valid;
      #1;
      if (hs) begin
         void'(fq.pop_front());
         taken++;
      end
      s_valid = (fq.size() > 0);
      s_data  = (fq.size() > 0) ? fq[0][7:0] : 8'h00;
      s_last  = (fq.size() > 0) ? fq[0][8] : 1'b0;
   end

   function automatic logic [7:0] mk_byte(input int seed, input int i);
      return 8'((seed + i * 61) & 255);
   endfunction

   task automatic run_burst(input int lpx, input int prep, input int zero, input int trl,
                            input int ext, input int nb, input int seed, input bit lastflag,
                            input int wait_n, input string tag);
      logic [7:0] bytes[$];
      cfg_lpx = CW'(lpx); cfg_prep = CW'(prep); cfg_zero = CW'(zero);
      cfg_trail = CW'(trl); cfg_exit = CW'(ext);
      taken = 0;
      for (int i = 0; i < nb; i++) begin
         bytes.push_back(mk_byte(seed, i));
         fq.push_back({(lastflag && i == nb - 1), mk_byte(seed, i)});
      end
      if (wait_n > 0) begin
         clk_lane_ready = 1'b0;
         burst_req = 1'b1;
         push_exp(3'd0, 1'b0, 2, wait_n);   // R2: no start without clock lane
         repeat (wait_n) @(posedge clk);
         #2;
         clk_lane_ready = 1'b1;
      end
      push_trace(lpx, prep, zero, trl, ext, bytes, 1'b1, 1'b1);
      burst_req = 1'b1;
      @(posedge clk);
      #2;
      burst_req = 1'b0;
      while (expq.size() != 0) @(negedge clk);
      @(posedge clk);
      #2;
      // R7 / R8: exactly the burst's bytes were consumed
      chk(taken == nb, "R7", {tag, " bytes taken"}, taken, nb);
      chk(fq.size() == 0, "R8", {tag, " bytes left"}, fq.size(), 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic [7:0] ba[$];
      logic [7:0] bb[$];
      int lenA;
      repeat (2) @(negedge clk);
      // R1: reset state held during reset
      chk(lane_code == 3'd0, "R1", "code in reset", lane_code, 0);
      chk(hs_bit == 1'b0, "R1", "bit in reset", hs_bit, 0);
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      @(negedge clk);
      chk(lane_code == 3'd0, "R1", "code after reset", lane_code, 0);
      chk(s_ready == 1'b0, "R1", "ready after reset", s_ready, 0);
      @(posedge clk);
      #2;

      // nominal lengths, three bytes, ended by last (R3 R4 R5 R6 R8 R9 R10)
      run_burst(7, 10, 3, 12, 12, 3, 8'h5A, 1'b1, 0, "nominal");
      // every length below its floor (R3 R4 R5 R9 R10)
      run_burst(0, 0, 0, 0, 0, 1, 8'hC3, 1'b1, 0, "floors");
      // prepare above its ceiling (R4)
      run_burst(5, 40, 2, 10, 10, 2, 8'h11, 1'b1, 0, "prep ceiling");
      // clock lane not ready yet (R2)
      run_burst(6, 9, 1, 11, 10, 1, 8'h7E, 1'b1, 5, "clock wait");
      // stream runs dry without last flag (R8)
      run_burst(5, 8, 2, 10, 10, 2, 8'h96, 1'b0, 0, "valid drop");
      // no payload at all: sync then trail of inverted bit 7 (R8 R9)
      run_burst(5, 8, 1, 10, 10, 0, 0, 1'b0, 0, "empty");

      // back-to-back under a held request (R10); A's last must stop A (R8)
      cfg_lpx = 8'd6; cfg_prep = 8'd9; cfg_zero = 8'd2; cfg_trail = 8'd10; cfg_exit = 8'd13;
      taken = 0;
      for (int i = 0; i < 2; i++) begin
         ba.push_back(mk_byte(8'h21, i));
         fq.push_back({(i == 1), mk_byte(8'h21, i)});
      end
      for (int i = 0; i < 3; i++) begin
         bb.push_back(mk_byte(8'hE4, i));
         fq.push_back({(i == 2), mk_byte(8'hE4, i)});
      end
      push_trace(6, 9, 2, 10, 13, ba, 1'b1, 1'b0);
      push_trace(6, 9, 2, 10, 13, bb, 1'b0, 1'b1);
      lenA = 1 + 6 + 9 + 2 + 8 + 16 + 10 + 13;
      burst_req = 1'b1;
      repeat (lenA + 3) @(posedge clk);
      #2;
      burst_req = 1'b0;
      while (expq.size() != 0) @(negedge clk);
      @(posedge clk);
      #2;
      chk(taken == 5, "R10", "back-to-back bytes taken", taken, 5);
      chk(fq.size() == 0, "R8", "back-to-back bytes left", fq.size(), 0);

      finish_run();
   end

endmodule